// File: doc/BRIEF.md
# Inclusive Two-Level Cache Tag Tracker

This block keeps the tags of a two-level cache hierarchy, a first level (L1) and a second level (L2). It tracks which line addresses each level holds, with no data storage. Both levels are set-associative and replace their least recently used line. One line address is offered at a time on a valid/ready handshake. For each access the block returns the L1 and L2 hit flags and any line addresses evicted from either level. It also keeps saturating event counters for each level.

Inclusion is kept at all times: every line held in L1 is also held in L2. An L1 hit is forwarded to L2 so that the line becomes most recent there as well. An L2 eviction that hits a line still held in L1 removes that L1 copy in the same operation.

Top module: `incl_cache_tracker`

## Requirements
- R1: After reset all lines in both levels are invalid, `req_ready_o` is 1, `rsp_valid_o` is 0 and all four counters are 0, so the first access to any address misses in both levels.
- R2: An access is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 in the following cycle. `rsp_valid_o` is 1 for exactly the next cycle, two edges after acceptance.
- R3: On an L1 hit the response has `rsp_l1_hit_o`=1 and `rsp_l2_hit_o`=1 and no eviction flag. The line becomes most recently used in both levels.
- R4: On an L1 miss that hits in L2, the line is allocated into L1 and made most recent in both levels. `rsp_l2_evict_o` is 0. `rsp_l1_evict_o` is 1 with the displaced L1 line only when the L1 set was full.
- R5: On a miss in both levels, the line is allocated in both levels as most recent. When the L2 set was full, its least recently used line is reported on `rsp_l2_evict_addr_o`. An evicted address never equals the requested one.
- R6: In each set of each level the victim is an invalid way if one exists, otherwise the least recently used way. Recency is kept correctly for any number of ways.
- R7: With 2 ways per level and line addresses 0, 2 and 4 in one set, the accesses 0, 2, 0, 4 evict line 2 from both levels. A following access to 2 reports an L2 miss and evicts line 0 from both levels.
- R8: Inclusion: an L1 hit always comes with an L2 hit, and every valid L1 victim is present in L2.
- R9: `rsp_back_inval_o` is 1 only when the line evicted from L2 was present in L1 at a way other than the one L1 would have replaced anyway. That copy is then removed and reported as the L1 eviction.
- R10: The L1 hit and miss counters advance once per access. The L2 hit and miss counters advance only on L1 misses. Every counter stops at 2^CNT_W-1.
- R11: The set index is the low log2(SETS) bits of the line address and is the same in both levels. Accesses to one set never change another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access offered |
| req_ready_o | output | 1 | Block can accept an access |
| req_addr_i | input | ADDR_W | Line address of the access |
| rsp_valid_o | output | 1 | Response fields are valid |
| rsp_l1_hit_o | output | 1 | Line was found in L1 |
| rsp_l2_hit_o | output | 1 | Line was found in L2 |
| rsp_l1_evict_o | output | 1 | A valid line left L1 |
| rsp_l1_evict_addr_o | output | ADDR_W | Line address that left L1 |
| rsp_l2_evict_o | output | 1 | A valid line left L2 |
| rsp_l2_evict_addr_o | output | ADDR_W | Line address that left L2 |
| rsp_back_inval_o | output | 1 | L2 eviction removed a further L1 copy |
| l1_hit_cnt_o | output | CNT_W | Saturating L1 hit count |
| l1_miss_cnt_o | output | CNT_W | Saturating L1 miss count |
| l2_hit_cnt_o | output | CNT_W | Saturating L2 hit count on L1 misses |
| l2_miss_cnt_o | output | CNT_W | Saturating L2 miss count on L1 misses |

## Verification
A corrupted recency order does not show as a wrong hit flag at once. It shows as a wrong evicted address on the next miss in that set, once the set is full. This can come many accesses after the fault, so every response is compared against an independent recency-list model over a long random stream. A lost L1-to-L2 recency update breaks inclusion, which appears as a stale L2 hit on the very next return to the evicted line. A second configuration with deeper L2 exercises the L1-miss/L2-hit path and the multi-way age ordering.

// File: rtl/cache_pkg.sv
package cache_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_set.sv
module lru_set
  import cache_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int WAY_W = idx_w(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] lru_way_o
);
  if (WAYS == 2) begin : g_bit
    logic lru_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lru_q <= 1'b0;
      else if (touch_i) lru_q <= ~touch_way_i[0];
    end
    assign lru_way_o = lru_q;

    assert_lru_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      touch_i |=> (lru_way_o != $past(touch_way_i)));
  end else begin : g_age
    // age 0 = most recent, WAYS-1 = least recent; ages stay a permutation
    logic [WAYS-1:0][WAY_W-1:0] age_q;
    logic [WAYS-1:0]            is_old;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i)          age_q[w] <= '0;
          else if (age_q[w] < age_q[touch_way_i]) age_q[w] <= age_q[w] + 1'b1;
        end
      end
    end

    always_comb begin
      lru_way_o = '0;
      for (int w = 0; w < WAYS; w++) begin
        is_old[w] = (age_q[w] == WAY_W'(WAYS - 1));
        if (is_old[w]) lru_way_o = WAY_W'(w);
      end
    end

    assert_lru_unique_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(is_old) == 1);
    assert_lru_not_touched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      touch_i |=> (lru_way_o != $past(touch_way_i)));
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         count_o <= '0;
    else if (inc_i && count_o != MaxVal) count_o <= count_o + 1'b1;
  end

  assert_cnt_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o >= $past(count_o)));
endmodule

// File: rtl/cache_level.sv
module cache_level
  import cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  localparam int WAY_W = idx_w(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic [WAYS-1:0]   hit_vec_o,
  output logic              vict_valid_o,
  output logic [WAY_W-1:0]  vict_way_o,
  output logic [ADDR_W-1:0] vict_addr_o,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic [WAYS-1:0]   probe_vec_o,
  input  logic              upd_en_i,
  input  logic              upd_alloc_i,
  input  logic [WAY_W-1:0]  upd_way_i,
  input  logic [ADDR_W-1:0] upd_addr_i
);
  localparam int SET_W = idx_w(SETS);

  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tag_q;
  logic [WAY_W-1:0]                      lru_way [SETS];

  logic [SET_W-1:0] look_set, probe_set, upd_set;
  assign look_set  = look_addr_i[SET_W-1:0];
  assign probe_set = probe_addr_i[SET_W-1:0];
  assign upd_set   = upd_addr_i[SET_W-1:0];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      hit_vec_o[w]   = valid_q[look_set][w]  && (tag_q[look_set][w]  == look_addr_i);
      probe_vec_o[w] = valid_q[probe_set][w] && (tag_q[probe_set][w] == probe_addr_i);
    end
  end

  // invalid way first, lowest index wins; else the set's LRU way
  always_comb begin
    vict_valid_o = 1'b1;
    vict_way_o   = lru_way[look_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[look_set][w]) begin
        vict_valid_o = 1'b0;
        vict_way_o   = WAY_W'(w);
      end
    end
    vict_addr_o = tag_q[look_set][vict_way_o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (upd_en_i && upd_alloc_i) begin
      valid_q[upd_set][upd_way_i] <= 1'b1;
      tag_q[upd_set][upd_way_i]   <= upd_addr_i;
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : g_set
    lru_set #(.WAYS(WAYS)) u_lru (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .touch_i    (upd_en_i && (upd_set == SET_W'(g))),
      .touch_way_i(upd_way_i),
      .lru_way_o  (lru_way[g])
    );
  end

  assert_no_dup_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));
endmodule

// File: rtl/incl_cache_tracker.sv
module incl_cache_tracker
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SETS    = 4,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_l1_hit_o,
  output logic              rsp_l2_hit_o,
  output logic              rsp_l1_evict_o,
  output logic [ADDR_W-1:0] rsp_l1_evict_addr_o,
  output logic              rsp_l2_evict_o,
  output logic [ADDR_W-1:0] rsp_l2_evict_addr_o,
  output logic              rsp_back_inval_o,
  output logic [CNT_W-1:0]  l1_hit_cnt_o,
  output logic [CNT_W-1:0]  l1_miss_cnt_o,
  output logic [CNT_W-1:0]  l2_hit_cnt_o,
  output logic [CNT_W-1:0]  l2_miss_cnt_o
);
  localparam int W1_W = idx_w(L1_WAYS);
  localparam int W2_W = idx_w(L2_WAYS);

  logic              pending_q;
  logic [ADDR_W-1:0] req_q;
  logic              accept;

  assign req_ready_o = !pending_q;
  assign accept      = req_valid_i && req_ready_o;

  logic [L1_WAYS-1:0] l1_hit_vec, l1_probe_vec;
  logic [L2_WAYS-1:0] l2_hit_vec, l2_probe_vec;
  logic               l1_vict_valid, l2_vict_valid;
  logic [W1_W-1:0]    l1_vict_way, l1_hit_way, l1_probe_way, l1_way;
  logic [W2_W-1:0]    l2_vict_way, l2_hit_way, l2_way;
  logic [ADDR_W-1:0]  l1_vict_addr, l2_vict_addr;
  logic               l1_hit, l2_hit, l1_probe_hit, l2_probe_hit;
  logic               l2_evict, back_inval, l1_evict;
  logic [ADDR_W-1:0]  l1_evict_addr;
  logic               l2_upd_en;

  always_comb begin
    l1_hit_way   = '0;
    l1_probe_way = '0;
    for (int w = 0; w < L1_WAYS; w++) begin
      if (l1_hit_vec[w])   l1_hit_way   = W1_W'(w);
      if (l1_probe_vec[w]) l1_probe_way = W1_W'(w);
    end
    l2_hit_way = '0;
    for (int w = 0; w < L2_WAYS; w++) begin
      if (l2_hit_vec[w]) l2_hit_way = W2_W'(w);
    end
  end

  assign l1_hit       = |l1_hit_vec;
  assign l2_hit       = |l2_hit_vec;
  assign l1_probe_hit = |l1_probe_vec;
  assign l2_probe_hit = |l2_probe_vec;

  assign l2_evict   = !l1_hit && !l2_hit && l2_vict_valid;
  // L2 victim still cached in L1 elsewhere: new line overwrites that copy
  assign back_inval = l2_evict && l1_probe_hit &&
                      (!l1_vict_valid || (l1_probe_way != l1_vict_way));
  assign l1_way        = l1_hit ? l1_hit_way : (back_inval ? l1_probe_way : l1_vict_way);
  assign l1_evict      = !l1_hit && (back_inval || l1_vict_valid);
  assign l1_evict_addr = back_inval ? l2_vict_addr : l1_vict_addr;
  assign l2_way        = l2_hit ? l2_hit_way : l2_vict_way;
  assign l2_upd_en     = pending_q && (l2_hit || !l1_hit);

  cache_level #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(L1_WAYS)) u_l1 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_addr_i (req_q),
    .hit_vec_o   (l1_hit_vec),
    .vict_valid_o(l1_vict_valid),
    .vict_way_o  (l1_vict_way),
    .vict_addr_o (l1_vict_addr),
    .probe_addr_i(l2_vict_addr),
    .probe_vec_o (l1_probe_vec),
    .upd_en_i    (pending_q),
    .upd_alloc_i (!l1_hit),
    .upd_way_i   (l1_way),
    .upd_addr_i  (req_q)
  );

  cache_level #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(L2_WAYS)) u_l2 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_addr_i (req_q),
    .hit_vec_o   (l2_hit_vec),
    .vict_valid_o(l2_vict_valid),
    .vict_way_o  (l2_vict_way),
    .vict_addr_o (l2_vict_addr),
    .probe_addr_i(l1_vict_addr),
    .probe_vec_o (l2_probe_vec),
    .upd_en_i    (l2_upd_en),
    .upd_alloc_i (!l2_hit),
    .upd_way_i   (l2_way),
    .upd_addr_i  (req_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q           <= 1'b0;
      req_q               <= '0;
      rsp_valid_o         <= 1'b0;
      rsp_l1_hit_o        <= 1'b0;
      rsp_l2_hit_o        <= 1'b0;
      rsp_l1_evict_o      <= 1'b0;
      rsp_l1_evict_addr_o <= '0;
      rsp_l2_evict_o      <= 1'b0;
      rsp_l2_evict_addr_o <= '0;
      rsp_back_inval_o    <= 1'b0;
    end else begin
      pending_q   <= accept;
      rsp_valid_o <= pending_q;
      if (accept) req_q <= req_addr_i;
      if (pending_q) begin
        rsp_l1_hit_o        <= l1_hit;
        rsp_l2_hit_o        <= l2_hit;
        rsp_l1_evict_o      <= l1_evict;
        rsp_l1_evict_addr_o <= l1_evict ? l1_evict_addr : '0;
        rsp_l2_evict_o      <= l2_evict;
        rsp_l2_evict_addr_o <= l2_evict ? l2_vict_addr : '0;
        rsp_back_inval_o    <= back_inval;
      end
    end
  end

  sat_counter #(.W(CNT_W)) u_l1_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pending_q && l1_hit), .count_o(l1_hit_cnt_o));
  sat_counter #(.W(CNT_W)) u_l1_miss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pending_q && !l1_hit), .count_o(l1_miss_cnt_o));
  sat_counter #(.W(CNT_W)) u_l2_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pending_q && !l1_hit && l2_hit),
    .count_o(l2_hit_cnt_o));
  sat_counter #(.W(CNT_W)) u_l2_miss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(pending_q && !l1_hit && !l2_hit),
    .count_o(l2_miss_cnt_o));

  assert_l1hit_implies_l2hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && l1_hit) |-> l2_hit);
  assert_l1_victim_in_l2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !l1_hit && l1_vict_valid) |-> l2_probe_hit);
  assert_rsp_follows_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |=> (rsp_valid_o && req_ready_o));
  assert_l1hit_no_evict_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && l1_hit) |=> (!rsp_l1_evict_o && !rsp_l2_evict_o));
  assert_evict_not_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_l2_evict_o) |-> (rsp_l2_evict_addr_o != req_q));
endmodule

// File: tb/tb_incl_cache_tracker.sv
module tb_incl_cache_tracker;
  localparam int AW = 4;
  localparam int NS = 2;
  localparam int CW = 4;
  localparam int CMAX = 15;
  localparam int GW = 6 + 2 * AW + 4 * CW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  always #4 clk = ~clk;

  logic rdy_a, rv_a, l1h_a, l2h_a, l1e_a, l2e_a, bi_a;
  logic [AW-1:0] l1a_a, l2a_a;
  logic [CW-1:0] c0_a, c1_a, c2_a, c3_a;
  logic rdy_b, rv_b, l1h_b, l2h_b, l1e_b, l2e_b, bi_b;
  logic [AW-1:0] l1a_b, l2a_b;
  logic [CW-1:0] c0_b, c1_b, c2_b, c3_b;

  incl_cache_tracker #(.ADDR_W(AW), .SETS(NS), .L1_WAYS(2), .L2_WAYS(2), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy_a),
    .req_addr_i(req_addr), .rsp_valid_o(rv_a), .rsp_l1_hit_o(l1h_a), .rsp_l2_hit_o(l2h_a),
    .rsp_l1_evict_o(l1e_a), .rsp_l1_evict_addr_o(l1a_a), .rsp_l2_evict_o(l2e_a),
    .rsp_l2_evict_addr_o(l2a_a), .rsp_back_inval_o(bi_a), .l1_hit_cnt_o(c0_a),
    .l1_miss_cnt_o(c1_a), .l2_hit_cnt_o(c2_a), .l2_miss_cnt_o(c3_a));

  incl_cache_tracker #(.ADDR_W(AW), .SETS(NS), .L1_WAYS(2), .L2_WAYS(4), .CNT_W(CW)) dut_w (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy_b),
    .req_addr_i(req_addr), .rsp_valid_o(rv_b), .rsp_l1_hit_o(l1h_b), .rsp_l2_hit_o(l2h_b),
    .rsp_l1_evict_o(l1e_b), .rsp_l1_evict_addr_o(l1a_b), .rsp_l2_evict_o(l2e_b),
    .rsp_l2_evict_addr_o(l2a_b), .rsp_back_inval_o(bi_b), .l1_hit_cnt_o(c0_b),
    .l1_miss_cnt_o(c1_b), .l2_hit_cnt_o(c2_b), .l2_miss_cnt_o(c3_b));

  logic [GW-1:0] got [2];
  assign got[0] = {rv_a, l1h_a, l2h_a, l1e_a, l1e_a ? l1a_a : AW'(0), l2e_a,
                   l2e_a ? l2a_a : AW'(0), bi_a, c0_a, c1_a, c2_a, c3_a};
  assign got[1] = {rv_b, l1h_b, l2h_b, l1e_b, l1e_b ? l1a_b : AW'(0), l2e_b,
                   l2e_b ? l2a_b : AW'(0), bi_b, c0_b, c1_b, c2_b, c3_b};

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;

  // reference model: per-set recency lists, index 0 = most recent
  int w2c [2] = '{2, 4};
  int m1 [2][NS][4];
  int n1 [2][NS];
  int m2 [2][NS][4];
  int n2 [2][NS];
  int cnt [2][4];
  bit e_l1h [2], e_l2h [2], e_l1e [2], e_l2e [2], e_bi [2];
  int e_l1a [2], e_l2a [2];

  function automatic int sat_inc(input int c);
    return (c < CMAX) ? c + 1 : c;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < NS; s++) begin n1[c][s] = 0; n2[c][s] = 0; end
      for (int k = 0; k < 4; k++) cnt[c][k] = 0;
    end
  endtask

  task automatic model_step(input int c, input int a);
    int s, i1, i2, j, t;
    s = a % NS;
    i1 = -1; i2 = -1;
    for (int k = 0; k < n1[c][s]; k++) if (m1[c][s][k] == a) i1 = k;
    for (int k = 0; k < n2[c][s]; k++) if (m2[c][s][k] == a) i2 = k;
    e_l1h[c] = (i1 >= 0); e_l2h[c] = (i2 >= 0);
    e_l1e[c] = 0; e_l2e[c] = 0; e_bi[c] = 0; e_l1a[c] = 0; e_l2a[c] = 0;
    if (i2 >= 0) begin
      t = m2[c][s][i2];
      for (int k = i2; k > 0; k--) m2[c][s][k] = m2[c][s][k-1];
      m2[c][s][0] = t;
    end
    if (i1 >= 0) begin
      for (int k = i1; k > 0; k--) m1[c][s][k] = m1[c][s][k-1];
      m1[c][s][0] = a;
      cnt[c][0] = sat_inc(cnt[c][0]);
    end else begin
      cnt[c][1] = sat_inc(cnt[c][1]);
      if (i2 >= 0) cnt[c][2] = sat_inc(cnt[c][2]);
      else begin
        cnt[c][3] = sat_inc(cnt[c][3]);
        if (n2[c][s] == w2c[c]) begin
          e_l2e[c] = 1; e_l2a[c] = m2[c][s][w2c[c]-1]; n2[c][s]--;
        end
        for (int k = n2[c][s]; k > 0; k--) m2[c][s][k] = m2[c][s][k-1];
        m2[c][s][0] = a; n2[c][s]++;
      end
      j = -1;
      if (e_l2e[c]) for (int k = 0; k < n1[c][s]; k++) if (m1[c][s][k] == e_l2a[c]) j = k;
      if (j >= 0) begin
        e_bi[c] = !(n1[c][s] == 2 && j == n1[c][s] - 1);
        e_l1e[c] = 1; e_l1a[c] = e_l2a[c];
        for (int k = j; k < n1[c][s] - 1; k++) m1[c][s][k] = m1[c][s][k+1];
        n1[c][s]--;
      end else if (n1[c][s] == 2) begin
        e_l1e[c] = 1; e_l1a[c] = m1[c][s][1]; n1[c][s]--;
      end
      for (int k = n1[c][s]; k > 0; k--) m1[c][s][k] = m1[c][s][k-1];
      m1[c][s][0] = a; n1[c][s]++;
    end
  endtask

  function automatic logic [GW-1:0] expv(input int c);
    return {1'b1, e_l1h[c], e_l2h[c], e_l1e[c], AW'(e_l1a[c]), e_l2e[c], AW'(e_l2a[c]),
            e_bi[c], CW'(cnt[c][0]), CW'(cnt[c][1]), CW'(cnt[c][2]), CW'(cnt[c][3])};
  endfunction

  task automatic chk(input string req, input logic [GW-1:0] g, input logic [GW-1:0] e);
    checks++;
    if (g !== e) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, g, e);
    end
  endtask

  task automatic chk1(input string req, input logic g, input logic e);
    checks++;
    if (g !== e) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", req, g, e);
    end
  endtask

  task automatic chka(input string req, input logic [AW-1:0] g, input int e);
    checks++;
    if (g !== AW'(e)) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, g, e);
    end
  endtask

  // called just after a negedge; returns just after the negedge where the response is visible
  task automatic access(input int a, input string req);
    model_step(0, a);
    model_step(1, a);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ready/valid while pending", {rdy_a, rv_a, rdy_b, rv_b}, 4'b0000);
    @(negedge clk);
    chk({req, " cfg2x2"}, got[0], expv(0));
    chk({req, " cfg2x4"}, got[1], expv(1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [15:0] lfsr;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {rdy_a, rv_a, c0_a, c1_a, c2_a, c3_a, rdy_b, rv_b},
        {1'b1, 1'b0, 16'h0, 1'b1, 1'b0});
    rst_ni = 1'b1;

    // R7 example in set 0 (lines 0, 2, 4), R1 first access misses, R6 fill before evict
    access(0, "R1 R6 first");
    chk1("R1 first access l1 hit", l1h_a, 1'b0);
    chk1("R6 no evict on fill", l1e_a | l2e_a, 1'b0);
    access(2, "R6 fill second way");
    access(0, "R3 l1 hit");
    chk1("R3 l1 hit flag", l1h_a, 1'b1);
    chk1("R3 l2 hit flag", l2h_a, 1'b1);
    access(4, "R7 step4");
    chk1("R7 l1 evict", l1e_a, 1'b1);
    chka("R7 l1 evict addr", l1a_a, 2);
    chka("R7 l2 evict addr", l2a_a, 2);
    chk1("R9 no back inval", bi_a, 1'b0);
    chka("R4 wide l1 evict addr", l1a_b, 2);
    chk1("R4 wide no l2 evict", l2e_b, 1'b0);
    access(2, "R7 step5");
    chk1("R7 l2 miss on return", l2h_a, 1'b0);
    chka("R7 order l1 evicts a1", l1a_a, 0);
    chka("R7 order l2 evicts a1", l2a_a, 0);
    chk1("R4 wide l1 miss l2 hit", {l1h_b, l2h_b} == 2'b01, 1'b1);
    chk1("R4 wide no l2 evict", l2e_b, 1'b0);
    access(1, "R11 other set");
    chk1("R11 other set no evict", l1e_a | l2e_a | l1h_a, 1'b0);

    // sweep: random stream compared against the model (R3 R4 R5 R6 R8 R9 R10)
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[AW-1:0]), "R5 R6 R8 R9 sweep");
    end

    // R10 saturation
    for (int i = 0; i < 20; i++) access(3, "R10 repeat");
    chka("R10 l1 hit count saturates", c0_a, CMAX);
    chk1("R10 wide l1 hit saturates", c0_b == CW'(CMAX), 1'b1);

    // R1 reset mid-run clears lines
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 counters after reset", {c0_a, c1_a, c2_a, c3_a, rv_a}, '0);
    rst_ni = 1'b1;
    model_reset();
    access(3, "R1 after reset");
    chk1("R1 line gone after reset", l1h_a | l2h_a, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule